// File: doc/BRIEF.md
# Open-Drain General-Purpose Pin Bank

This block controls a small bank of general-purpose pins. Each pin is set as an input or as an open-drain output. The setting comes from a control register made of direction bits and drive bits. An output pin can only pull its line low or let it go. A pull-up outside the block sets the level of a released line. An input pin's level goes through a two-stage synchronizer and appears in a status word, which a serial readout returns to the host.

The control register loads when the host pulses a write strobe. One clock edge later, the register contents are copied into a per-pin applied stage, and that stage drives the pad. A write therefore reaches the pads on the second rising edge after the strobe is sampled. Out of reset every pin is an input and every line is released.

Top module: `gpio_od_bank`

## Requirements
- R1: During and after reset, with no write, every direction bit is 0 (input), every drive bit is 1, every `pad_oe` bit is 0 and `pad_out` is 0.
- R2: A rising edge with `cfg_we`=1 loads `cfg_dir` and `cfg_val` into the control register. A rising edge with `cfg_we`=0 leaves the register unchanged, so the values on `cfg_dir`/`cfg_val` have no effect on the pads.
- R3: A control register change appears on `pad_oe` and in the readout mask one rising edge after the edge that loaded the register. The pads therefore keep their old state for exactly one cycle after the loading edge.
- R4: A pin with direction 1 and drive 0 pulls low: its `pad_oe` bit is 1, and `pad_out` is always 0.
- R5: A pin with direction 1 and drive 1 is released: its `pad_oe` bit is 0.
- R6: A pin with direction 0 never drives: its `pad_oe` bit is 0 whatever its drive bit is.
- R7: For an input pin, the `rd_status` bit equals the `pad_in` level (low reads 0, high reads 1) as sampled two rising edges earlier.
- R8: For an output pin, the `rd_status` bit is 0 whatever the pad level is.
- R9: Bit i of every vector port belongs to the same pin i. Pins do not affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| cfg_we | input | 1 | Control register write strobe |
| cfg_dir | input | NUM_PINS | Direction bits to load, 1 = output |
| cfg_val | input | NUM_PINS | Drive bits to load, 0 = pull low, 1 = release |
| pad_in | input | NUM_PINS | Pad levels seen at the pins |
| pad_oe | output | NUM_PINS | Per-pin output enable for the pad cell |
| pad_out | output | NUM_PINS | Per-pin drive value, always low (open-drain) |
| rd_status | output | NUM_PINS | Status word returned by the serial readout |

## Verification
The bench runs every combination of direction word, drive word and pad level word on the three pins, 512 combinations in all. This separates the pull-low, released and input cases on every pin, and any mix-up between bit positions shows up as a wrong bit. Each pad pattern is applied while some pins are outputs, so a readout that leaks through an output pin gets caught. Separate passes check two things. The first is that pads keep their old state on the cycle after a write. The second is that bit changes offered with the strobe low never reach the pads.

// File: rtl/gpio_od_pkg.sv
package gpio_od_pkg;

  // Enable mask for the pad cells: only output pins whose drive bit is low pull the line.
  function automatic logic [31:0] od_pull_mask(input logic [31:0] dir, input logic [31:0] val);
    return dir & ~val;
  endfunction

  // Readout word: synchronized level for input pins, zero for output pins.
  function automatic logic [31:0] od_read_word(input logic [31:0] dir, input logic [31:0] lvl);
    return ~dir & lvl;
  endfunction

endpackage

// File: rtl/gpio_od_sync.sv
module gpio_od_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end

    // R7
    sync_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chain[s] == $past(chain[s-1]));
  end

  assign sync_out = chain[LAST];
endmodule

// File: rtl/gpio_od_pin.sv
module gpio_od_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_dir,
  input  logic ctl_val,
  output logic app_dir,
  output logic app_oe
);
  import gpio_od_pkg::*;

  logic [31:0] pull_w;
  assign pull_w = od_pull_mask({31'd0, ctl_dir}, {31'd0, ctl_val});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      app_dir <= 1'b0;
      app_oe  <= 1'b0;
    end else begin
      app_dir <= ctl_dir;
      app_oe  <= pull_w[0];
    end
  end

  // R6
  input_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !app_dir |-> !app_oe);

  // R4
  pull_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    app_oe |-> ($past(ctl_dir) && !$past(ctl_val)));
endmodule

// File: rtl/gpio_od_bank.sv
module gpio_od_bank #(
  parameter int NUM_PINS    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [NUM_PINS-1:0] cfg_dir,
  input  logic [NUM_PINS-1:0] cfg_val,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] rd_status
);
  import gpio_od_pkg::*;

  localparam int PAD_W = 32 - NUM_PINS;

  logic [NUM_PINS-1:0] ctl_dir_q;
  logic [NUM_PINS-1:0] ctl_val_q;
  logic [NUM_PINS-1:0] app_dir_w;
  logic [NUM_PINS-1:0] app_oe_w;
  logic [NUM_PINS-1:0] lvl_sync_w;
  logic [31:0]         read_w;

  // Control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_dir_q <= '0;
      ctl_val_q <= '1;
    end else if (cfg_we) begin
      ctl_dir_q <= cfg_dir;
      ctl_val_q <= cfg_val;
    end
  end

  // R2
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(ctl_dir_q) && $stable(ctl_val_q)));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    gpio_od_pin u_pin (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl_dir (ctl_dir_q[i]),
      .ctl_val (ctl_val_q[i]),
      .app_dir (app_dir_w[i]),
      .app_oe  (app_oe_w[i])
    );

    // R3
    dir_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      app_dir_w[i] == $past(ctl_dir_q[i]));
  end

  gpio_od_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (lvl_sync_w)
  );

  assign read_w    = od_read_word({{PAD_W{1'b0}}, app_dir_w}, {{PAD_W{1'b0}}, lvl_sync_w});
  assign rd_status = read_w[NUM_PINS-1:0];
  assign pad_oe    = app_oe_w;
  assign pad_out   = '0;

  // R8
  out_pin_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status & app_dir_w) == '0);
endmodule

// File: tb/tb_gpio_od_bank.sv
`timescale 1ns/1ps
module tb_gpio_od_bank;
  localparam int N = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic [N-1:0] cfg_dir = '0;
  logic [N-1:0] cfg_val = '0;
  logic [N-1:0] pad_in = '1;
  logic [N-1:0] pad_oe;
  logic [N-1:0] pad_out;
  logic [N-1:0] rd_status;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  gpio_od_bank #(.NUM_PINS(N), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dir(cfg_dir), .cfg_val(cfg_val),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .rd_status(rd_status)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Expected pull mask: bit i set only for an output pin with drive bit 0.
  function automatic logic [N-1:0] exp_oe(input logic [N-1:0] d, input logic [N-1:0] v);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = (d[i] == 1'b1 && v[i] == 1'b0) ? 1'b1 : 1'b0;
    return r;
  endfunction

  // Expected readout: pad level for input pins, 0 for output pins.
  function automatic logic [N-1:0] exp_rd(input logic [N-1:0] d, input logic [N-1:0] p);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = d[i] ? 1'b0 : p[i];
    return r;
  endfunction

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [N-1:0] d, input logic [N-1:0] v);
    cfg_dir = d; cfg_val = v; cfg_we = 1'b1;
    cycles(1);
    cfg_we = 1'b0;
  endtask

  initial begin
    cycles(3);
    // R1: reset state
    check("R1 oe in reset", pad_oe, '0);
    check("R1 out in reset", pad_out, '0);
    rst_n = 1'b1;
    cycles(3);
    check("R1 oe after reset", pad_oe, '0);
    check("R1 readout after reset, all inputs", rd_status, '1);

    // R3: old pad state holds one cycle after the loading edge
    write_cfg(3'b111, 3'b000);
    check("R3 one edge after load, old state", pad_oe, '0);
    cycles(1);
    check("R3 two edges after load, new state", pad_oe, 3'b111);
    write_cfg(3'b000, 3'b111);
    check("R3 release lag", pad_oe, 3'b111);
    cycles(1);
    check("R3 released", pad_oe, '0);

    // R7: two-stage readout latency
    pad_in = 3'b010;
    cycles(1);
    check("R7 one edge after pad change", rd_status, 3'b111);
    cycles(1);
    check("R7 two edges after pad change", rd_status, 3'b010);

    // Full sweep: R4 R5 R6 R7 R8 R9
    for (int d = 0; d < 8; d++) begin
      for (int v = 0; v < 8; v++) begin
        write_cfg(d[N-1:0], v[N-1:0]);
        cycles(1);
        check("R4/R5/R6/R9 pad_oe", pad_oe, exp_oe(d[N-1:0], v[N-1:0]));
        check("R4 pad_out low", pad_out, '0);
        for (int p = 0; p < 8; p++) begin
          pad_in = p[N-1:0];
          cycles(2);
          check("R7/R8/R9 rd_status", rd_status, exp_rd(d[N-1:0], p[N-1:0]));
        end
      end
    end

    // R2: with the strobe low, new bits do not reach the pads
    write_cfg(3'b101, 3'b100);
    cycles(1);
    check("R2 loaded", pad_oe, 3'b001);
    cfg_dir = 3'b010; cfg_val = 3'b000; cfg_we = 1'b0;
    cycles(3);
    check("R2 ignored without strobe", pad_oe, 3'b001);
    pad_in = 3'b111;
    cycles(2);
    check("R2 readout mask kept", rd_status, 3'b010);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule